// File: doc/BRIEF.md
# Ordered Store Buffer

This block holds stores between issue and memory. Each store first claims a slot through an allocate port, in program order. The slot number it gets back is attached to the two micro-ops of the store. One op computes the address and the access size. The other produces the write data. The two ops are scheduled independently, so they may write their halves into the slot in either order.

Retirement marks stores as non-speculative, one per commit pulse, oldest first. The head slot is offered to memory only when it has been committed and holds both halves. Stores therefore leave strictly in allocation order, and no store ever reaches memory speculatively.

A mispredict flush throws away every uncommitted slot and rolls allocation back. Committed slots survive the flush and drain normally. The memory side places the data in its byte lanes, and produces a byte-enable mask from the access size and the low address bits.

Top module: `store_queue`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o` is 1, `alloc_id_o` is 0 and `mem_valid_o` is 0.
- R2: Allocation hands out slot ids in sequence, wrapping modulo DEPTH. When DEPTH slots are held, `alloc_ready_o` is 0 and an allocate request is ignored: `alloc_id_o` does not move. `alloc_ready_o` is also 0 during a flush cycle.
- R3: The address half and the data half of a store may arrive in either order. A store is offered to memory only after both halves have been written.
- R4: A store is never offered to memory before a commit pulse has marked it. Each `commit_i` pulse marks the oldest unmarked store.
- R5: Stores are offered in allocation order. A younger store that is complete and committed waits while an older store is incomplete.
- R6: While `mem_valid_o` is 1 and `mem_ready_i` is 0, the next cycle keeps `mem_valid_o` at 1 and keeps address, enables and data unchanged.
- R7: `flush_i` discards all uncommitted slots. After the flush, the next slot allocated is the one that follows the last committed store. Committed stores still drain to memory.
- R8: Size code 0 selects 1 byte, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes. Let lo be the value of address bits [1:0]. `mem_be_o` is the size mask shifted left by lo and cut to 4 lanes. `mem_data_o` is the write data shifted left by 8*lo bits. `mem_addr_o` is the address with bits [1:0] cleared.
- R9: A commit pulse while no uncommitted store is held has no effect: a store allocated and completed later stays unoffered until its own commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Request a slot for the next store in program order |
| alloc_ready_o | output | 1 | Slot available this cycle |
| alloc_id_o | output | IDW | Id of the slot handed out on allocation |
| addr_valid_i | input | 1 | Address half write |
| addr_id_i | input | IDW | Slot targeted by the address half |
| addr_i | input | AW | Store byte address |
| size_i | input | 2 | Access size code |
| data_valid_i | input | 1 | Data half write |
| data_id_i | input | IDW | Slot targeted by the data half |
| data_i | input | DW | Store data, right-justified |
| commit_i | input | 1 | Oldest uncommitted store is now non-speculative |
| flush_i | input | 1 | Discard all uncommitted stores |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | AW | Lane-aligned write address |
| mem_be_o | output | DW/8 | Byte enables |
| mem_data_o | output | DW | Lane-placed write data |

## Verification
The bench builds the buffer with DEPTH 4 and a 16-bit address. With only four slots, the random stream wraps the pointers and hits the full condition often. A flush then frequently lands while committed and uncommitted slots are both held, across the wrap point. The 32-bit data path is kept, so every size code meets every low-address offset, including the offsets where a wider access is cut at the top lane.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRSV = 2'd3
  } sz_e;
endpackage

// File: rtl/sq_slot.sv
module sq_slot #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           aw_i,
  input  logic [AW-1:0]  addr_i,
  input  sq_pkg::sz_e    sz_i,
  input  logic           dw_i,
  input  logic [DW-1:0]  data_i,
  input  logic           sel_i,
  output logic           addr_ok_o,
  output logic           data_ok_o,
  output logic [AW-1:0]  addr_o,
  output sq_pkg::sz_e    sz_o,
  output logic [DW-1:0]  data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_ok_o <= 1'b0;
      data_ok_o <= 1'b0;
      addr_o    <= '0;
      sz_o      <= sq_pkg::SZ_BYTE;
      data_o    <= '0;
    end else begin
      // a write in the allocation cycle wins over the clear
      if (clr_i) begin
        addr_ok_o <= 1'b0;
        data_ok_o <= 1'b0;
      end
      if (aw_i) begin
        addr_ok_o <= 1'b1;
        addr_o    <= addr_i;
        sz_o      <= sz_i;
      end
      if (dw_i) begin
        data_ok_o <= 1'b1;
        data_o    <= data_i;
      end
    end
  end

  AST_SEL_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> (addr_ok_o && data_ok_o)); // R3
endmodule

// File: rtl/sq_lane_fmt.sv
module sq_lane_fmt #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LANES = DW / 8,
  parameter int OFW = $clog2(LANES)
) (
  input  logic [AW-1:0]    addr_i,
  input  sq_pkg::sz_e      sz_i,
  input  logic [DW-1:0]    data_i,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] be_o,
  output logic [DW-1:0]    data_o
);
  logic [OFW-1:0] lo;
  logic [OFW:0]   nbytes;
  logic [OFW:0]   lo_x;
  logic [OFW:0]   hi_x;

  assign lo   = addr_i[OFW-1:0];
  assign lo_x = {1'b0, lo};
  assign hi_x = lo_x + nbytes;

  always_comb begin
    unique case (sz_i)
      sq_pkg::SZ_BYTE: nbytes = (OFW+1)'(1);
      sq_pkg::SZ_HALF: nbytes = (OFW+1)'(2);
      default:         nbytes = (OFW+1)'(4);
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFW:0] LANE = (OFW+1)'(l);
    assign be_o[l] = (LANE >= lo_x) && (LANE < hi_x);
  end

  assign data_o = data_i << {lo, 3'b000};
  assign addr_o = {addr_i[AW-1:OFW], {OFW{1'b0}}};
endmodule

// File: rtl/store_queue.sv
module store_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDW   = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_valid_i,
  output logic            alloc_ready_o,
  output logic [IDW-1:0]  alloc_id_o,
  input  logic            addr_valid_i,
  input  logic [IDW-1:0]  addr_id_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [1:0]      size_i,
  input  logic            data_valid_i,
  input  logic [IDW-1:0]  data_id_i,
  input  logic [DW-1:0]   data_i,
  input  logic            commit_i,
  input  logic            flush_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW/8-1:0] mem_be_o,
  output logic [DW-1:0]   mem_data_o
);
  // DEPTH must be a power of two: pointers carry one wrap bit
  localparam int PW = IDW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0]  head_q, cmt_q, tail_q, cmt_nxt, used;
  logic [IDW-1:0] head_idx;
  logic           full, alloc_fire, commit_fire, mem_fire, has_cmt, has_pend;

  logic [DEPTH-1:0] aok, dok;
  logic [AW-1:0]    s_addr [DEPTH];
  sq_pkg::sz_e      s_sz   [DEPTH];
  logic [DW-1:0]    s_data [DEPTH];

  assign used          = tail_q - head_q;
  assign full          = (used == FULL_CNT);
  assign alloc_ready_o = !full && !flush_i;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign alloc_id_o    = tail_q[IDW-1:0];
  assign has_cmt       = (cmt_q != head_q);
  assign has_pend      = (tail_q != cmt_q);
  assign commit_fire   = commit_i && has_pend;
  assign cmt_nxt       = cmt_q + PW'(commit_fire);
  assign head_idx      = head_q[IDW-1:0];
  assign mem_valid_o   = has_cmt && aok[head_idx] && dok[head_idx];
  assign mem_fire      = mem_valid_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + PW'(mem_fire);
      cmt_q  <= cmt_nxt;
      tail_q <= flush_i ? cmt_nxt : tail_q + PW'(alloc_fire);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [IDW-1:0] ID = IDW'(i);
    sq_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (alloc_fire && (alloc_id_o == ID)),
      .aw_i      (addr_valid_i && (addr_id_i == ID)),
      .addr_i    (addr_i),
      .sz_i      (sq_pkg::sz_e'(size_i)),
      .dw_i      (data_valid_i && (data_id_i == ID)),
      .data_i    (data_i),
      .sel_i     (mem_fire && (head_idx == ID)),
      .addr_ok_o (aok[i]),
      .data_ok_o (dok[i]),
      .addr_o    (s_addr[i]),
      .sz_o      (s_sz[i]),
      .data_o    (s_data[i])
    );
  end

  sq_lane_fmt #(.AW(AW), .DW(DW)) u_fmt (
    .addr_i (s_addr[head_idx]),
    .sz_i   (s_sz[head_idx]),
    .data_i (s_data[head_idx]),
    .addr_o (mem_addr_o),
    .be_o   (mem_be_o),
    .data_o (mem_data_o)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= FULL_CNT); // R2
  AST_ALLOC_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire |=> (alloc_id_o == IDW'($past(alloc_id_o) + 1'b1))); // R2
  AST_CMT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_q - head_q) <= used); // R4
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_be_o) && $stable(mem_data_o))); // R6
  AST_FLUSH_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tail_q == cmt_q)); // R7
endmodule

// File: tb/store_queue_test.sv
`timescale 1ns/1ps
module store_queue_test;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int IDW   = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic alloc_valid, alloc_ready, addr_valid, data_valid, commit, flush, mem_valid, mem_ready;
  logic [IDW-1:0] alloc_id, addr_id, data_id;
  logic [AW-1:0]  addr, mem_addr;
  logic [1:0]     size;
  logic [DW-1:0]  data, mem_data;
  logic [3:0]     mem_be;

  int checks = 0, errors = 0;
  bit done = 0;

  // model
  int m_head = 0, m_cmt = 0, m_tail = 0;
  bit m_aok [DEPTH], m_dok [DEPTH];
  logic [AW-1:0] m_addr [DEPTH];
  logic [1:0]    m_sz   [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  bit prev_stall = 0;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;

  always #2 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid), .alloc_ready_o(alloc_ready), .alloc_id_o(alloc_id),
    .addr_valid_i(addr_valid), .addr_id_i(addr_id), .addr_i(addr), .size_i(size),
    .data_valid_i(data_valid), .data_id_i(data_id), .data_i(data),
    .commit_i(commit), .flush_i(flush),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_data_o(mem_data));

  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] lo);
    logic [7:0] base;
    base = (sz == 2'd0) ? 8'h1 : (sz == 2'd1) ? 8'h3 : 8'hF;
    return 4'(base << lo);
  endfunction

  function automatic logic [DW-1:0] exp_data(logic [DW-1:0] d, logic [1:0] lo);
    return d << (8 * lo);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit al, bit awv, int awid, logic [AW-1:0] ad, logic [1:0] sz,
                      bit dwv, int dwid, logic [DW-1:0] d, bit cm, bit fl, bit rdy);
    bit e_rdy, e_mv, mfire;
    int h;
    alloc_valid = al; addr_valid = awv; addr_id = IDW'(awid); addr = ad; size = sz;
    data_valid = dwv; data_id = IDW'(dwid); data = d; commit = cm; flush = fl; mem_ready = rdy;
    #1;
    h     = m_head % DEPTH;
    e_rdy = (m_tail - m_head != DEPTH) && !fl;
    e_mv  = (m_cmt > m_head) && m_aok[h] && m_dok[h];
    chk(alloc_ready == e_rdy, "R2 alloc_ready", 64'(alloc_ready), 64'(e_rdy));
    chk(alloc_id == IDW'(m_tail % DEPTH), "R2 alloc_id", 64'(alloc_id), 64'(m_tail % DEPTH));
    chk(mem_valid == e_mv, "R5 mem_valid", 64'(mem_valid), 64'(e_mv));
    if (prev_stall)
      chk(mem_valid && mem_addr == prev_addr && mem_data == prev_data, "R6 hold",
          64'(mem_addr), 64'(prev_addr));
    if (e_mv && mem_valid) begin
      chk(mem_addr == (m_addr[h] & ~AW'(3)), "R8 addr", 64'(mem_addr), 64'(m_addr[h] & ~AW'(3)));
      chk(mem_be == exp_be(m_sz[h], m_addr[h][1:0]), "R8 be", 64'(mem_be),
          64'(exp_be(m_sz[h], m_addr[h][1:0])));
      chk(mem_data == exp_data(m_data[h], m_addr[h][1:0]), "R8 data", 64'(mem_data),
          64'(exp_data(m_data[h], m_addr[h][1:0])));
    end
    prev_stall = mem_valid && !rdy;
    prev_addr  = mem_addr;
    prev_data  = mem_data;
    // model update
    mfire = e_mv && rdy;
    if (al && e_rdy) begin
      m_aok[m_tail % DEPTH] = 0; m_dok[m_tail % DEPTH] = 0; m_tail++;
    end
    if (awv) begin m_aok[awid] = 1; m_addr[awid] = ad; m_sz[awid] = sz; end
    if (dwv) begin m_dok[dwid] = 1; m_data[dwid] = d; end
    if (mfire) m_head++;
    if (cm && m_cmt < m_tail - ((al && e_rdy) ? 1 : 0)) m_cmt++;
    if (fl) m_tail = m_cmt;
    @(negedge clk);
  endtask

  task automatic idle(bit rdy);
    step(0, 0, 0, '0, 2'd0, 0, 0, '0, 0, 0, rdy);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int id, id2;
    void'($urandom(32'h5eed1234));
    alloc_valid = 0; addr_valid = 0; data_valid = 0; commit = 0; flush = 0; mem_ready = 0;
    addr_id = '0; data_id = '0; addr = '0; size = '0; data = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(alloc_ready && alloc_id == 0 && !mem_valid, "R1 reset state",
        64'({alloc_ready, alloc_id, mem_valid}), 64'h8);
    @(negedge clk);

    // data half first, commit before address arrives
    id = m_tail % DEPTH;
    step(1, 0, 0, '0, 0, 0, 0, '0, 0, 0, 1);
    step(0, 0, 0, '0, 0, 1, id, 32'h0000_A1B2, 1, 0, 1);
    chk(!mem_valid, "R3 data only", 64'(mem_valid), 64'h0);
    step(0, 1, id, 16'h1231, 2'd1, 0, 0, '0, 0, 0, 0);
    chk(mem_valid && mem_be == 4'b0110, "R8 half at offset 1", 64'(mem_be), 64'h6);
    idle(0);
    idle(1);

    // complete but uncommitted
    id = m_tail % DEPTH;
    step(1, 0, 0, '0, 0, 0, 0, '0, 0, 0, 1);
    step(0, 1, id, 16'h4003, 2'd0, 1, id, 32'h55, 0, 0, 1);
    idle(1);
    chk(!mem_valid, "R4 uncommitted held", 64'(mem_valid), 64'h0);
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 0, 1);
    chk(mem_valid && mem_be == 4'b1000, "R4 after commit", 64'(mem_be), 64'h8);
    idle(1);

    // younger complete waits for older incomplete
    id = m_tail % DEPTH;
    step(1, 0, 0, '0, 0, 0, 0, '0, 0, 0, 1);
    id2 = m_tail % DEPTH;
    step(1, 1, id2, 16'h7770, 2'd2, 1, id2, 32'hCAFE_F00D, 1, 0, 1);
    step(0, 1, id, 16'h8882, 2'd2, 0, 0, '0, 1, 0, 1);
    chk(!mem_valid, "R5 younger blocked", 64'(mem_valid), 64'h0);
    step(0, 0, 0, '0, 0, 1, id, 32'h1122_3344, 0, 0, 0);
    chk(mem_valid && mem_addr == 16'h8880 && mem_be == 4'b1100, "R5 older first",
        64'(mem_addr), 64'h8880);
    idle(1); idle(1); idle(1);

    // commit with nothing pending
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 0, 1);
    id = m_tail % DEPTH;
    step(1, 0, 0, '0, 0, 0, 0, '0, 0, 0, 1);
    step(0, 1, id, 16'h0100, 2'd2, 1, id, 32'h9, 0, 0, 1);
    idle(1);
    chk(!mem_valid, "R9 stray commit ignored", 64'(mem_valid), 64'h0);
    step(0, 0, 0, '0, 0, 0, 0, '0, 1, 0, 0);

    // flush keeps committed, drops the rest
    id = m_tail % DEPTH;
    step(1, 0, 0, '0, 0, 0, 0, '0, 0, 0, 0);
    step(1, 0, 0, '0, 0, 0, 0, '0, 1, 0, 0);
    step(0, 0, 0, '0, 0, 0, 0, '0, 0, 1, 0);
    chk(alloc_id == IDW'(id + 1), "R7 rollback", 64'(alloc_id), 64'(IDW'(id + 1)));
    step(0, 1, id, 16'h2222, 2'd0, 1, id, 32'h77, 0, 0, 1);
    idle(1);
    idle(1);
    chk(!mem_valid && m_head == m_cmt, "R7 committed drained", 64'(mem_valid), 64'h0);

    // fill to full, extra request ignored
    repeat (DEPTH) step(1, 0, 0, '0, 0, 0, 0, '0, 0, 0, 1);
    id = alloc_id;
    step(1, 0, 0, '0, 0, 0, 0, '0, 0, 0, 1);
    chk(!alloc_ready && alloc_id == id, "R2 full stall", 64'(alloc_id), 64'(id));
    step(0, 0, 0, '0, 0, 0, 0, '0, 0, 1, 1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit awv, dwv;
      int cnt, aid, did;
      cnt = m_tail - m_head;
      awv = 0; dwv = 0; aid = 0; did = 0;
      if (cnt > 0) begin
        aid = (m_head + int'($urandom_range(cnt - 1))) % DEPTH;
        awv = !m_aok[aid] && ($urandom_range(1) == 1);
        did = (m_head + int'($urandom_range(cnt - 1))) % DEPTH;
        dwv = !m_dok[did] && ($urandom_range(1) == 1);
      end
      step($urandom_range(2) != 0, awv, aid, AW'($urandom), 2'($urandom), dwv, did, $urandom,
           $urandom_range(2) == 0, $urandom_range(49) == 0, $urandom_range(3) != 0);
    end

    // drain
    for (int n = 0; n < 40; n++) begin
      int cnt, h;
      cnt = m_tail - m_head;
      h = m_head % DEPTH;
      if (cnt > 0)
        step(0, !m_aok[h], h, 16'h0F00, 2'd2, !m_dok[h], h, 32'h1, 1, 0, 1);
      else
        idle(1);
    end
    chk(!mem_valid && alloc_ready, "R4 drained", 64'(mem_valid), 64'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule